// File: doc/BRIEF.md
# Outstanding Bus Transaction Table

This block sits in every cache controller on a split-transaction bus and keeps one record for each transaction still in flight. The bus gives each request a small tag when the request wins arbitration. Every controller writes the request into the slot whose index is that tag, so all copies of the table hold the same entries. A later response that carries the same tag releases the slot. Each slot records the block address, the kind of request, whether this controller issued it, whether this controller has asked to take the returning data, and this cache's snoop result once that result is known.

The table compares all valid slots at once against two addresses: the address of a processor request that is about to be issued, and the address of a request currently on the bus. On the processor side it decides between two outcomes. A read that finds a pending read can join it and take its data. Any other hit must wait, because it conflicts with the pending request. On the bus side it detects a competing invalidating request that hits this controller's own pending upgrade, and converts that upgrade into a read-exclusive. When a response appears, the table reports whether to load its data and whether to assert the shared line.

Top module: `txn_track_table`

## Requirements
- R1: A bus request (`breq_valid`) is written into slot `breq_tag`. From the next cycle on, a processor lookup of its address reports `cpu_hit_tag` equal to that tag.
- R2: A slot keeps its request type, encoded as read=0, read-exclusive=1, upgrade=2, writeback=3, and its snoop result. The snoop result comes either with the request (`breq_snp_known`, `breq_snp`) or later through `snp_valid`/`snp_tag`/`snp_state`. An update aimed at an empty slot is dropped.
- R3: `cpu_match` follows, in the same cycle, from `cpu_valid` together with a parallel comparison of `cpu_addr` against every valid slot. When more than one slot hits, the lowest index is reported.
- R4: A response (`bresp_valid`) empties slot `bresp_tag` at the next edge. If a new request writes the same tag in that same cycle, the new request is kept.
- R5: `cpu_conflict` is 1 when a processor lookup hits and it is not the case that both the processor request and the hit slot are reads.
- R6: A processor read that hits a pending read raises `cpu_grab` in the same cycle and sets that slot's want-data bit at the next edge, which `cpu_hit_want` then shows.
- R7: A slot's original-requester bit equals `breq_own` at the time of writing. When a response hits a valid slot whose original or want bit is set, `resp_grab` is raised.
- R8: `resp_shared` is raised during a response to a valid slot that has the want bit set and the original bit clear.
- R9: A processor read that hits a pending read-exclusive reports `cpu_conflict`=1 and `cpu_grab`=0, so the read waits and retries.
- R10: A bus upgrade or read-exclusive from another controller (`breq_own`=0) whose address hits a valid slot holding this controller's own upgrade raises `upg_demote` in that cycle. The slot's type becomes read-exclusive at the next edge.
- R11: An empty slot never produces a hit. After reset every slot is empty.
- R12: `bus_match` is raised in the same cycle when a valid bus request's address equals the address of any valid slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| breq_valid | input | 1 | Bus request present this cycle |
| breq_tag | input | 3 | Tag assigned to the bus request |
| breq_addr | input | 12 | Block address of the bus request |
| breq_type | input | 2 | Request type (0 rd, 1 rdx, 2 upg, 3 wb) |
| breq_own | input | 1 | Request was issued by this controller |
| breq_snp_known | input | 1 | Snoop result is already known |
| breq_snp | input | 2 | Snoop result given with the request |
| bresp_valid | input | 1 | Bus response present this cycle |
| bresp_tag | input | 3 | Tag carried by the response |
| snp_valid | input | 1 | Late snoop result update |
| snp_tag | input | 3 | Slot of the snoop update |
| snp_state | input | 2 | Snoop result value |
| cpu_valid | input | 1 | Processor lookup present |
| cpu_addr | input | 12 | Processor block address |
| cpu_type | input | 2 | Processor request type |
| cpu_match | output | 1 | Lookup hit a valid slot |
| cpu_conflict | output | 1 | Processor request must be held back |
| cpu_grab | output | 1 | Read may join a pending read |
| cpu_hit_tag | output | 3 | Index of the hit slot |
| cpu_hit_type | output | 2 | Type held in the hit slot |
| cpu_hit_orig | output | 1 | Original-requester bit of the hit slot |
| cpu_hit_want | output | 1 | Want-data bit of the hit slot |
| cpu_hit_known | output | 1 | Snoop result known in the hit slot |
| cpu_hit_snp | output | 2 | Snoop result of the hit slot |
| bus_match | output | 1 | Bus request address hits a valid slot |
| upg_demote | output | 1 | Own upgrade is turned into read-exclusive |
| resp_grab | output | 1 | Load the data of the current response |
| resp_shared | output | 1 | Assert the shared line for this response |

## Verification
All lookup, bus-match, demote and response indications are combinational, so each is due in the same cycle as its stimulus. The bench drives inputs on the falling edge and samples 2 ns later. Table changes (writing, freeing, want bit, snoop update, demotion) appear one edge later. The bench therefore applies each one to its own model at the rising edge and checks it with a lookup on the next falling edge. The sweep tries every processor request type against every slot, so the conflict and grab decisions and their effect on the want bits are checked for all type pairs.

// File: rtl/txn_pkg.sv
// Shared types for the outstanding transaction table.
// Assumes a two-bit request type field that every controller decodes the same way.
package txn_pkg;
    typedef enum logic [1:0] {
        TT_RD  = 2'd0,
        TT_RDX = 2'd1,
        TT_UPG = 2'd2,
        TT_WB  = 2'd3
    } req_t;
endpackage

// File: rtl/txn_entry.sv
// One slot of the transaction table: holds one outstanding request and
// compares its address against the processor and bus addresses.
// Assumes alloc and free are never both asserted for a different request,
// and that alloc takes priority over every other update.
module txn_entry
    import txn_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SNP_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic              free_i,
    input  logic [ADDR_W-1:0] a_addr_i,
    input  req_t              a_type_i,
    input  logic              a_own_i,
    input  logic              a_known_i,
    input  logic [SNP_W-1:0]  a_snp_i,
    input  logic              snp_upd_i,
    input  logic [SNP_W-1:0]  snp_st_i,
    input  logic              grab_set_i,
    input  logic              demote_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    output logic              vld_o,
    output req_t              type_o,
    output logic              orig_o,
    output logic              want_o,
    output logic              known_o,
    output logic [SNP_W-1:0]  snp_o,
    output logic              cpu_hit_o,
    output logic              bus_hit_o
);
    logic [ADDR_W-1:0] addr_q;

    // Slot state: write on alloc, release on free, otherwise apply updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o   <= 1'b0;
            addr_q  <= '0;
            type_o  <= TT_RD;
            orig_o  <= 1'b0;
            want_o  <= 1'b0;
            known_o <= 1'b0;
            snp_o   <= '0;
        end else if (alloc_i) begin
            vld_o   <= 1'b1;
            addr_q  <= a_addr_i;
            type_o  <= a_type_i;
            orig_o  <= a_own_i;
            want_o  <= 1'b0;
            known_o <= a_known_i;
            snp_o   <= a_snp_i;
        end else if (free_i) begin
            vld_o   <= 1'b0;
        end else if (vld_o) begin
            if (snp_upd_i) begin
                known_o <= 1'b1;
                snp_o   <= snp_st_i;
            end
            if (grab_set_i) begin
                want_o <= 1'b1;
            end
            if (demote_i && orig_o && type_o == TT_UPG) begin
                type_o <= TT_RDX;
            end
        end
    end

    // Address compare, masked so an empty slot never hits.
    always_comb begin
        cpu_hit_o = vld_o && (addr_q == cpu_addr_i);
        bus_hit_o = vld_o && (addr_q == bus_addr_i);
    end
endmodule

// File: rtl/txn_first.sv
// Lowest-index selector: gives the index of the lowest set request bit.
// Assumes N is at least 2; idx_o is 0 when no bit is set.
module txn_first #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    // Scan from the top down so that the lowest set bit is written last.
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/txn_track_table.sv
// Outstanding bus transaction table for one cache controller.
// Slots are written at the bus tag and searched associatively against
// processor and bus addresses. Assumes NUM_ENT is a power of two and that
// the bus hands out each tag only after the response carrying it.
module txn_track_table
    import txn_pkg::*;
#(
    parameter int NUM_ENT = 8,
    parameter int ADDR_W  = 12,
    parameter int SNP_W   = 2,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              breq_valid,
    input  logic [IDX_W-1:0]  breq_tag,
    input  logic [ADDR_W-1:0] breq_addr,
    input  logic [1:0]        breq_type,
    input  logic              breq_own,
    input  logic              breq_snp_known,
    input  logic [SNP_W-1:0]  breq_snp,
    input  logic              bresp_valid,
    input  logic [IDX_W-1:0]  bresp_tag,
    input  logic              snp_valid,
    input  logic [IDX_W-1:0]  snp_tag,
    input  logic [SNP_W-1:0]  snp_state,
    input  logic              cpu_valid,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        cpu_type,
    output logic              cpu_match,
    output logic              cpu_conflict,
    output logic              cpu_grab,
    output logic [IDX_W-1:0]  cpu_hit_tag,
    output logic [1:0]        cpu_hit_type,
    output logic              cpu_hit_orig,
    output logic              cpu_hit_want,
    output logic              cpu_hit_known,
    output logic [SNP_W-1:0]  cpu_hit_snp,
    output logic              bus_match,
    output logic              upg_demote,
    output logic              resp_grab,
    output logic              resp_shared
);
    logic [NUM_ENT-1:0] ent_vld, ent_orig, ent_want, ent_known;
    logic [NUM_ENT-1:0] cpu_hit, bus_hit, own_upg;
    req_t               ent_type [NUM_ENT];
    logic [SNP_W-1:0]   ent_snp  [NUM_ENT];
    logic               hit_any, both_rd, competing, resp_live;
    logic [IDX_W-1:0]   hit_idx;

    // A request from another controller that would invalidate our copy.
    assign competing = breq_valid && !breq_own &&
                       (req_t'(breq_type) == TT_UPG || req_t'(breq_type) == TT_RDX);

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
        txn_entry #(.ADDR_W(ADDR_W), .SNP_W(SNP_W)) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_i    (breq_valid && breq_tag == IDX_W'(g)),
            .free_i     (bresp_valid && bresp_tag == IDX_W'(g)),
            .a_addr_i   (breq_addr),
            .a_type_i   (req_t'(breq_type)),
            .a_own_i    (breq_own),
            .a_known_i  (breq_snp_known),
            .a_snp_i    (breq_snp),
            .snp_upd_i  (snp_valid && snp_tag == IDX_W'(g)),
            .snp_st_i   (snp_state),
            .grab_set_i (cpu_grab && hit_idx == IDX_W'(g)),
            .demote_i   (competing && bus_hit[g]),
            .cpu_addr_i (cpu_addr),
            .bus_addr_i (breq_addr),
            .vld_o      (ent_vld[g]),
            .type_o     (ent_type[g]),
            .orig_o     (ent_orig[g]),
            .want_o     (ent_want[g]),
            .known_o    (ent_known[g]),
            .snp_o      (ent_snp[g]),
            .cpu_hit_o  (cpu_hit[g]),
            .bus_hit_o  (bus_hit[g])
        );
        assign own_upg[g] = ent_orig[g] && ent_type[g] == TT_UPG;
    end

    txn_first #(.N(NUM_ENT), .IDX_W(IDX_W)) u_first (
        .req_i (cpu_hit),
        .any_o (hit_any),
        .idx_o (hit_idx)
    );

    // Processor-side decision: join a pending read or hold back the issue.
    always_comb begin
        cpu_match     = cpu_valid && hit_any;
        both_rd       = req_t'(cpu_type) == TT_RD && ent_type[hit_idx] == TT_RD;
        cpu_grab      = cpu_match && both_rd;
        cpu_conflict  = cpu_match && !both_rd;
        cpu_hit_tag   = cpu_match ? hit_idx : '0;
        cpu_hit_type  = cpu_match ? ent_type[hit_idx] : 2'd0;
        cpu_hit_orig  = cpu_match && ent_orig[hit_idx];
        cpu_hit_want  = cpu_match && ent_want[hit_idx];
        cpu_hit_known = cpu_match && ent_known[hit_idx];
        cpu_hit_snp   = cpu_match ? ent_snp[hit_idx] : '0;
    end

    // Bus-side decisions: address match, upgrade demotion, response data use.
    always_comb begin
        bus_match   = breq_valid && |bus_hit;
        upg_demote  = competing && |(bus_hit & own_upg);
        resp_live   = bresp_valid && ent_vld[bresp_tag];
        resp_grab   = resp_live && (ent_orig[bresp_tag] || ent_want[bresp_tag]);
        resp_shared = resp_live && ent_want[bresp_tag] && !ent_orig[bresp_tag];
    end
endmodule

// File: rtl/txn_track_checker.sv
// Protocol checker for txn_track_table, attached with bind below.
// Assumes the bound table's slot valid vector is named ent_vld.
module txn_track_checker #(
    parameter int NUM_ENT = 8,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               breq_valid,
    input logic [IDX_W-1:0]   breq_tag,
    input logic               bresp_valid,
    input logic [IDX_W-1:0]   bresp_tag,
    input logic               cpu_match,
    input logic [IDX_W-1:0]   cpu_hit_tag,
    input logic               cpu_conflict,
    input logic               cpu_grab,
    input logic               bus_match,
    input logic               upg_demote,
    input logic               resp_grab,
    input logic               resp_shared,
    input logic [NUM_ENT-1:0] ent_vld
);
    a_r1_alloc_valid: assert property (@(posedge clk) disable iff (!rst_n)
        breq_valid |=> ent_vld[$past(breq_tag)]);

    a_r4_free_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bresp_valid && !(breq_valid && breq_tag == bresp_tag)) |=> !ent_vld[$past(bresp_tag)]);

    a_r5_grab_or_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_conflict && cpu_grab));

    a_r8_shared_needs_grab: assert property (@(posedge clk) disable iff (!rst_n)
        resp_shared |-> resp_grab);

    a_r11_hit_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_match |-> ent_vld[cpu_hit_tag]);

    a_r10_demote_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        upg_demote |-> bus_match);
endmodule

bind txn_track_table txn_track_checker #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .breq_valid   (breq_valid),
    .breq_tag     (breq_tag),
    .bresp_valid  (bresp_valid),
    .bresp_tag    (bresp_tag),
    .cpu_match    (cpu_match),
    .cpu_hit_tag  (cpu_hit_tag),
    .cpu_conflict (cpu_conflict),
    .cpu_grab     (cpu_grab),
    .bus_match    (bus_match),
    .upg_demote   (upg_demote),
    .resp_grab    (resp_grab),
    .resp_shared  (resp_shared),
    .ent_vld      (ent_vld)
);

// File: tb/txn_track_table_bench.sv
// Bench for txn_track_table: a requirement-level model of the slots,
// inputs driven on the falling edge, outputs sampled 2 ns later.
module txn_track_table_bench;
    localparam int N  = 8;
    localparam int AW = 12;
    localparam int SW = 2;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          breq_valid, breq_own, breq_snp_known;
    logic [IW-1:0] breq_tag;
    logic [AW-1:0] breq_addr;
    logic [1:0]    breq_type;
    logic [SW-1:0] breq_snp;
    logic          bresp_valid;
    logic [IW-1:0] bresp_tag;
    logic          snp_valid;
    logic [IW-1:0] snp_tag;
    logic [SW-1:0] snp_state;
    logic          cpu_valid;
    logic [AW-1:0] cpu_addr;
    logic [1:0]    cpu_type;
    logic          cpu_match, cpu_conflict, cpu_grab;
    logic [IW-1:0] cpu_hit_tag;
    logic [1:0]    cpu_hit_type;
    logic          cpu_hit_orig, cpu_hit_want, cpu_hit_known;
    logic [SW-1:0] cpu_hit_snp;
    logic          bus_match, upg_demote, resp_grab, resp_shared;

    txn_track_table u_txn_track_table (.*);

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    bit       m_vld [N];
    int       m_addr[N];
    int       m_type[N];
    bit       m_orig[N];
    bit       m_want[N];
    bit       m_known[N];
    int       m_snp [N];

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int find(int a);
        for (int i = 0; i < N; i++) if (m_vld[i] && m_addr[i] == a) return i;
        return -1;
    endfunction

    task automatic check_lookup();
        int  k  = find(int'(cpu_addr));
        bit  m  = cpu_valid && k >= 0;
        bit  rr = m && cpu_type == 2'd0 && m_type[k] == 0;
        chk(m ? "R3 match" : "R11 no match", int'(cpu_match), int'(m));
        if (m) begin
            chk("R1 tag", int'(cpu_hit_tag), k);
            chk("R2 type", int'(cpu_hit_type), m_type[k]);
            chk((cpu_type == 2'd0 && m_type[k] == 1) ? "R9 conflict" : "R5 conflict",
                int'(cpu_conflict), int'(!rr));
            chk("R6 grab", int'(cpu_grab), int'(rr));
            chk("R6 want", int'(cpu_hit_want), int'(m_want[k]));
            chk("R7 orig", int'(cpu_hit_orig), int'(m_orig[k]));
            chk("R2 known", int'(cpu_hit_known), int'(m_known[k]));
            if (m_known[k]) chk("R2 snoop", int'(cpu_hit_snp), m_snp[k]);
        end else begin
            chk("R5 no conflict", int'(cpu_conflict), 0);
            chk("R6 no grab", int'(cpu_grab), 0);
        end
    endtask

    task automatic check_bus();
        int  k = find(int'(breq_addr));
        bit  comp = breq_valid && !breq_own && (breq_type == 2'd1 || breq_type == 2'd2);
        bit  dm = 0;
        for (int i = 0; i < N; i++)
            if (m_vld[i] && m_addr[i] == int'(breq_addr) && m_orig[i] && m_type[i] == 2) dm = comp;
        chk("R12 bus match", int'(bus_match), int'(breq_valid && k >= 0));
        chk("R10 demote", int'(upg_demote), int'(dm));
    endtask

    task automatic check_resp();
        int  t  = int'(bresp_tag);
        bit  rv = bresp_valid && m_vld[t];
        chk("R7 resp grab", int'(resp_grab), int'(rv && (m_orig[t] || m_want[t])));
        chk("R8 resp shared", int'(resp_shared), int'(rv && m_want[t] && !m_orig[t]));
    endtask

    // Model update at the rising edge, from the inputs driven this cycle.
    task automatic model_edge();
        int g = find(int'(cpu_addr));
        bit gr = cpu_valid && g >= 0 && cpu_type == 2'd0 && m_type[g] == 0;
        bit comp = breq_valid && !breq_own && (breq_type == 2'd1 || breq_type == 2'd2);
        for (int i = 0; i < N; i++) begin
            bit bh = m_vld[i] && m_addr[i] == int'(breq_addr);
            if (breq_valid && int'(breq_tag) == i) begin
                m_vld[i] = 1; m_addr[i] = int'(breq_addr); m_type[i] = int'(breq_type);
                m_orig[i] = breq_own; m_want[i] = 0; m_known[i] = breq_snp_known;
                m_snp[i] = int'(breq_snp);
            end else if (bresp_valid && int'(bresp_tag) == i) begin
                m_vld[i] = 0;
            end else if (m_vld[i]) begin
                if (snp_valid && int'(snp_tag) == i) begin m_known[i] = 1; m_snp[i] = int'(snp_state); end
                if (gr && g == i) m_want[i] = 1;
                if (comp && bh && m_orig[i] && m_type[i] == 2) m_type[i] = 1;
            end
        end
    endtask

    task automatic step();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        breq_valid = 0; bresp_valid = 0; snp_valid = 0; cpu_valid = 0;
    endtask

    task automatic lookup(int a, int t);
        cpu_valid = 1; cpu_addr = AW'(a); cpu_type = 2'(t);
        #2 check_lookup();
        step();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 0; m_addr[i] = 0; m_type[i] = 0; m_orig[i] = 0;
            m_want[i] = 0; m_known[i] = 0; m_snp[i] = 0;
        end
        rst_n = 0; breq_valid = 0; breq_tag = 0; breq_addr = 0; breq_type = 0;
        breq_own = 0; breq_snp_known = 0; breq_snp = 0; bresp_valid = 0; bresp_tag = 0;
        snp_valid = 0; snp_tag = 0; snp_state = 0; cpu_valid = 0; cpu_addr = 0; cpu_type = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R11: empty table after reset never hits.
        for (int a = 0; a < N; a++) lookup('h100 + a, 0);

        // R1 R2 R12: fill every slot; tag i gets type i%4, own for i<4.
        for (int i = 0; i < N; i++) begin
            breq_valid = 1; breq_tag = IW'(i); breq_addr = AW'('h100 + i);
            breq_type = 2'(i % 4); breq_own = (i < 4); breq_snp_known = (i == 5);
            breq_snp = 2'd1;
            #2 check_bus();
            step();
        end

        // R3 R5 R6 R9: every processor type against every slot, then recheck wants.
        for (int i = 0; i < N; i++)
            for (int t = 0; t < 4; t++) lookup('h100 + i, t);
        for (int i = 0; i < N; i++) lookup('h100 + i, 1);
        lookup('h1FF, 0);
        cpu_addr = AW'('h100); cpu_type = 0;
        #2 check_lookup();  // R3: cpu_valid low gives no match
        step();

        // R2: late snoop update to a live slot, and to an empty one later.
        snp_valid = 1; snp_tag = 3'd3; snp_state = 2'd2;
        step();
        lookup('h103, 3);

        // R4: free slot 7.
        bresp_valid = 1; bresp_tag = 3'd7;
        #2 check_resp();
        step();
        lookup('h107, 0);
        snp_valid = 1; snp_tag = 3'd7; snp_state = 2'd3;  // R2: dropped on empty slot
        step();

        // R10 R12: another controller's upgrade hits our own upgrade in slot 2.
        breq_valid = 1; breq_tag = 3'd7; breq_addr = AW'('h102); breq_type = 2'd2;
        breq_own = 0; breq_snp_known = 0;
        #2 check_bus();
        step();
        lookup('h102, 0);  // R3: lowest index 2 wins; R10: type now 1

        // R7 R8: responses for own read, grabbed foreign read, and read-exclusive.
        bresp_valid = 1; bresp_tag = 3'd0; #2 check_resp(); step();
        bresp_valid = 1; bresp_tag = 3'd4; #2 check_resp(); step();
        bresp_valid = 1; bresp_tag = 3'd1; #2 check_resp(); step();
        lookup('h100, 0);
        lookup('h104, 0);

        // R4: free and rewrite the same tag in one cycle, new request kept.
        breq_valid = 1; breq_tag = 3'd5; breq_addr = AW'('h155); breq_type = 2'd0;
        breq_own = 1; breq_snp_known = 0;
        bresp_valid = 1; bresp_tag = 3'd5;
        #2 check_resp();
        step();
        lookup('h155, 0);
        lookup('h105, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule